// File: doc/BRIEF.md
# SPI Register Target with Previous-Frame Echo

This block is a SPI target that reads and writes a small file of 8-bit registers. Every transaction is one fixed frame of 17 bits, sent most significant bit first while the select line is held low. The frame carries a direction bit, an 8-bit register address and an 8-bit data field. A frame acts on the register file only if the select line returns high after exactly 17 clock pulses. Frames of any other length are dropped.

The target never answers within the frame that asks. While a frame is clocked in, the target shifts out the whole frame it accepted last. A read therefore gets its data back during the frame that follows it. For a read, the data field of the returned frame holds the register contents in place of the host's data bits. The serial pins are sampled in a single system clock domain through synchronizers, so SCLK must run well below the system clock. The MISO output enable is driven straight from the select pin, with no clock in the path.

Top module: `spi_echo_regslave`

## Requirements
- R1: Frame bits arrive MSB first. Bit 16 is the direction (1 = read, 0 = write), bits 15..8 are the address and bits 7..0 are the data. MOSI is sampled on rising SCLK (mode 0, SCLK idles low).
- R2: `miso_oe` is the inverse of `ss_n` at all times, with no clock in the path. `miso` is 0 whenever `ss_n` is high.
- R3: While `ss_n` is high, activity on SCLK and MOSI changes no register and does not change the frame returned next.
- R4: A write frame stores its data field in the addressed register when `ss_n` rises after exactly 17 rising SCLK edges.
- R5: During a frame, `miso` carries the previously accepted 17-bit frame MSB first. Its first bit is valid as soon as `ss_n` is low, before any SCLK edge, and each following bit appears after a falling SCLK edge.
- R6: After a write frame, the next frame returns that write frame unchanged.
- R7: After a read frame, the next frame returns direction 1, the same address, and the addressed register's contents as data.
- R8: A frame of 16 or 18 bits (any count other than 17) writes nothing and leaves the returned frame unchanged.
- R9: Reset clears every register and the stored frame, so the first frame after reset returns all zeros.
- R10: Addresses at or above NUM_REGS read as zero and ignore writes.
- R11: Each accepted in-range write raises `reg_wr_en` for exactly one clock, with the address and data. The register is updated on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| ss_n | input | 1 | Frame select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host; 0 when not enabled |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_wr_en | output | 1 | One-cycle pulse on an accepted in-range write |
| reg_wr_addr | output | 8 | Address of the write being reported |
| reg_wr_data | output | 8 | Data of the write being reported |
| regs_flat | output | NUM_REGS*8 | All register contents; register k sits in bits 8k+7..8k |

## Verification
The assertions assume that SCLK, SS_N and MOSI change slowly compared with the system clock. Each level must stay stable for several system cycles, so that the synchronizers see every SCLK edge once, and SS_N must stay high for a few cycles between frames. The bench keeps to these limits by holding every serial level for six system clocks and leaving twelve idle cycles after each frame. It changes inputs only on falling system-clock edges. The check that MISO is enabled with no clock runs between clock edges, just after SS_N falls.

// File: rtl/spi_echo_pkg.sv
// Package: frame layout shared by the SPI echo register target.
// Assumes the fixed 17-bit frame: direction, 8-bit address, 8-bit data.
package spi_echo_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int CNT_W   = 5;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/spi_sync_level.sv
// Module: multi-stage synchronizer for one asynchronous serial pin.
// Assumes the pin changes slower than STAGES+1 system clocks.
module spi_sync_level #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
// Module: frame capture, bit counting, accept decision and MISO shifting.
// Assumes synchronized SCLK/SS/MOSI levels; ss_n_raw is the raw pin and is
// used only for the output enable, with no clock in the path.
module spi_frame_engine
    import spi_echo_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sclk_lvl,
    input  logic   ss_lvl,
    input  logic   mosi_lvl,
    input  logic   ss_n_raw,
    input  frame_t echo_i,
    output frame_t frame_o,
    output logic   commit_o,
    output logic   miso,
    output logic   miso_oe
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic               sclk_d, ss_d;
    logic               sclk_rise, sclk_fall, ss_rise;
    logic [FRAME_W-1:0] in_sr, out_sr;
    logic [CNT_W-1:0]   bit_cnt;
    logic               commit_q;

    // Delay copies of the synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            ss_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_lvl;
            ss_d   <= ss_lvl;
        end
    end

    assign sclk_rise = sclk_lvl & ~sclk_d & ~ss_lvl;
    assign sclk_fall = ~sclk_lvl & sclk_d & ~ss_lvl;
    assign ss_rise   = ss_lvl & ~ss_d;

    // Capture, count, decide acceptance and shift the echo out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sr    <= '0;
            out_sr   <= '0;
            bit_cnt  <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (ss_lvl) begin
                bit_cnt <= '0;
                out_sr  <= echo_i;
                if (ss_rise && bit_cnt == CNT_FULL) commit_q <= 1'b1;
            end else begin
                if (sclk_rise) begin
                    in_sr <= {in_sr[FRAME_W-2:0], mosi_lvl};
                    if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
                end
                if (sclk_fall) out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign frame_o  = frame_t'(in_sr);
    assign commit_o = commit_q;
    assign miso_oe  = ~ss_n_raw;
    assign miso     = ~ss_n_raw & out_sr[FRAME_W-1];
endmodule

// File: rtl/spi_regfile.sv
// Module: NUM_REGS x 8-bit register file with range-checked access.
// Assumes NUM_REGS <= 256; out-of-range reads give zero, writes are dropped.
module spi_regfile
    import spi_echo_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [ADDR_W-1:0]          raddr,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Hold one register; load it when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)                             regs_q[g] <= '0;
            else if (we && waddr == ADDR_W'(g))     regs_q[g] <= wdata;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
    end

    // Read mux; unmatched addresses return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr == ADDR_W'(i)) rdata = regs_q[i];
        end
    end
endmodule

// File: rtl/spi_echo_regslave.sv
// Module: SPI register target returning the previously accepted frame.
// Assumes SCLK/SS_N/MOSI levels last several clk cycles; mode 0 timing.
module spi_echo_regslave
    import spi_echo_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       ss_n,
    input  logic                       mosi,
    output logic                       miso,
    output logic                       miso_oe,
    output logic                       reg_wr_en,
    output logic [ADDR_W-1:0]          reg_wr_addr,
    output logic [DATA_W-1:0]          reg_wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    localparam int       NPINS    = 3;
    localparam [2:0]     PIN_RSTV = 3'b010;   // {sclk, ss_n, mosi}

    logic [NPINS-1:0] pin_raw, pin_lvl;
    frame_t           frame_in, echo_q;
    logic             commit;
    logic             in_range;
    logic [DATA_W-1:0] rd_data;

    assign pin_raw = {sclk, ss_n, mosi};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        spi_sync_level #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(PIN_RSTV[g])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_raw[g]),
            .dout (pin_lvl[g])
        );
    end

    spi_frame_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_lvl(pin_lvl[2]),
        .ss_lvl  (pin_lvl[1]),
        .mosi_lvl(pin_lvl[0]),
        .ss_n_raw(ss_n),
        .echo_i  (echo_q),
        .frame_o (frame_in),
        .commit_o(commit),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    spi_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (commit & ~frame_in.rd),
        .waddr    (frame_in.addr),
        .wdata    (frame_in.data),
        .raddr    (frame_in.addr),
        .rdata    (rd_data),
        .regs_flat(regs_flat)
    );

    assign in_range = int'(frame_in.addr) < NUM_REGS;

    // Load the echo frame and report writes when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_q      <= '0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            if (commit) begin
                if (frame_in.rd) begin
                    echo_q <= '{rd: 1'b1, addr: frame_in.addr, data: rd_data};
                end else begin
                    echo_q <= frame_in;
                    if (in_range) begin
                        reg_wr_en   <= 1'b1;
                        reg_wr_addr <= frame_in.addr;
                        reg_wr_data <= frame_in.data;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_echo_regslave_chk.sv
// Checker: port-level properties of the SPI echo register target.
module spi_echo_regslave_chk #(
    parameter int NUM_REGS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ss_n,
    input logic                  miso,
    input logic                  miso_oe,
    input logic                  reg_wr_en,
    input logic [7:0]            reg_wr_addr,
    input logic [7:0]            reg_wr_data,
    input logic [NUM_REGS*8-1:0] regs_flat
);
    function automatic logic [7:0] pick(input logic [NUM_REGS*8-1:0] f,
                                        input logic [7:0] a);
        pick = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (a == 8'(i)) pick = f[i*8 +: 8];
        end
    endfunction

    // R2: enable tracks the select pin
    a_r2_oe_tracks_ssn: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe == !ss_n);
    // R2: no data driven while deselected
    a_r2_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !miso);
    // R11: write report lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    // R10: reported writes are in range
    a_r10_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> int'(reg_wr_addr) < NUM_REGS);
    // R4: registers change only with a reported write
    a_r4_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_flat != $past(regs_flat)) |-> reg_wr_en);
    // R4: reported data landed at the reported address
    a_r4_data_landed: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> pick(regs_flat, reg_wr_addr) == reg_wr_data);
endmodule

bind spi_echo_regslave spi_echo_regslave_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_n       (ss_n),
    .miso       (miso),
    .miso_oe    (miso_oe),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data),
    .regs_flat  (regs_flat)
);

// File: tb/spi_echo_regslave_tb_top.sv
// Bench: vector table of frames and expected echoes, then directed tests.
module spi_echo_regslave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NREGS      = 16;
    localparam int NVEC       = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, reg_wr_en;
    logic [7:0] reg_wr_addr, reg_wr_data;
    logic [NREGS*8-1:0] regs_flat;

    int n_checks = 0, n_fails = 0, pulses = 0;
    logic [7:0] last_addr, last_data;
    logic [7:0] mdl [NREGS];
    logic [16:0] got;
    logic oe_first, bit_first;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_echo_regslave #(.NUM_REGS(NREGS)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .reg_wr_en(reg_wr_en),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .regs_flat(regs_flat)
    );

    // Row: {frame sent, frame expected on MISO}; frame = {rd, addr, data}
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b0, 8'h03, 8'h5A,  1'b0, 8'h00, 8'h00},
        {1'b0, 8'h07, 8'hC3,  1'b0, 8'h03, 8'h5A},
        {1'b1, 8'h03, 8'h00,  1'b0, 8'h07, 8'hC3},
        {1'b1, 8'h07, 8'hFF,  1'b1, 8'h03, 8'h5A},
        {1'b0, 8'h20, 8'h11,  1'b1, 8'h07, 8'hC3},
        {1'b1, 8'h20, 8'h00,  1'b0, 8'h20, 8'h11},
        {1'b1, 8'h00, 8'h00,  1'b1, 8'h20, 8'h00},
        {1'b0, 8'h0F, 8'hA5,  1'b1, 8'h00, 8'h00},
        {1'b1, 8'h0F, 8'h00,  1'b0, 8'h0F, 8'hA5},
        {1'b0, 8'h00, 8'h00,  1'b1, 8'h0F, 8'hA5}
    };

    task automatic check(input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NREGS*8-1:0] model_flat();
        logic [NREGS*8-1:0] f;
        for (int i = 0; i < NREGS; i++) f[i*8 +: 8] = mdl[i];
        return f;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Send nbits of bits (MSB first) in one select window; capture MISO.
    task automatic send(input int nbits, input logic [17:0] bits);
        int k;
        k = 0;
        got = '0;
        @(negedge clk);
        ss_n = 1'b0;
        #1;
        oe_first  = miso_oe;
        bit_first = miso;
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = bits[i];
            repeat (HALF) @(negedge clk);
            if (k < 17) got[16-k] = miso;
            k++;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        ss_n = 1'b1;
        mosi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // Record reported writes away from the active edge.
    always @(negedge clk) begin
        if (reg_wr_en) begin
            pulses++;
            last_addr = reg_wr_addr;
            last_data = reg_wr_data;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        for (int i = 0; i < NREGS; i++) mdl[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R9: reset state
        check("R9 regs after reset", 128'(regs_flat), 128'(model_flat()));
        check("R2 oe idle", 128'(miso_oe), 128'(0));
        check("R11 no pulse in reset", 128'(reg_wr_en), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 R4 R5 R6 R7 R10: table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [16:0] fr, ex;
            fr = VEC[v][33:17];
            ex = VEC[v][16:0];
            send(17, {1'b0, fr});
            check($sformatf("R5/R6/R7 echo row %0d", v), 128'(got), 128'(ex));
            if (!fr[16] && int'(fr[15:8]) < NREGS) mdl[fr[15:8]] = fr[7:0];
            check($sformatf("R4/R10 regs row %0d", v), 128'(regs_flat), 128'(model_flat()));
        end
        check("R11 pulse count in-range writes", 128'(pulses), 128'(4));

        // R8: short and long frames are dropped
        send(16, 18'h0FFFF);
        check("R8 16-bit frame no write", 128'(regs_flat), 128'(model_flat()));
        send(18, {1'b0, 8'h03, 8'hFF, 1'b0});
        check("R8 18-bit frame no write", 128'(regs_flat), 128'(model_flat()));

        // R3: clocking while deselected
        mosi = 1'b1;
        for (int i = 0; i < 17; i++) begin
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        mosi = 1'b0;
        repeat (12) @(negedge clk);
        check("R3 idle clocks no write", 128'(regs_flat), 128'(model_flat()));

        send(17, {1'b0, 1'b1, 8'h03, 8'h00});
        check("R8/R3 echo unchanged", 128'(got), 128'({1'b0, 8'h00, 8'h00}));
        check("R2 oe at select, no clock", 128'(oe_first), 128'(1));
        send(17, {1'b0, 1'b1, 8'h0F, 8'h00});
        check("R7 read after drops", 128'(got), 128'({1'b1, 8'h03, 8'h5A}));
        check("R5 first bit before SCLK", 128'(bit_first), 128'(1));
        check("R2 oe after deselect", 128'(miso_oe), 128'(0));
        check("R2 miso quiet deselected", 128'(miso), 128'(0));

        // R11: write report contents; out-of-range write gives no report
        pulses = 0;
        send(17, {1'b0, 1'b0, 8'h05, 8'h77});
        mdl[5] = 8'h77;
        check("R11 one pulse", 128'(pulses), 128'(1));
        check("R11 addr/data", 128'({last_addr, last_data}), 128'(16'h0577));
        send(17, {1'b0, 1'b0, 8'h40, 8'h11});
        check("R10/R11 out-of-range no pulse", 128'(pulses), 128'(1));
        check("R10 out-of-range no write", 128'(regs_flat), 128'(model_flat()));

        // R9: reset in mid-run clears registers and echo
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NREGS; i++) mdl[i] = 8'h00;
        repeat (4) @(negedge clk);
        check("R9 regs cleared", 128'(regs_flat), 128'(model_flat()));
        send(17, {1'b0, 1'b1, 8'h07, 8'h00});
        check("R9 echo cleared", 128'(got), 128'(0));
        send(17, {1'b0, 1'b0, 8'h00, 8'h00});
        check("R7/R9 read of cleared reg", 128'(got), 128'({1'b1, 8'h07, 8'h00}));

        summary();
    end
endmodule